// File: doc/BRIEF.md
# Clos Middle-Stage Path Allocator

This block sets up and tears down circuits in a three-stage unbuffered Clos switch. The switch has `NUM_SW` first-stage (ingress) switches and `NUM_SW` third-stage (egress) switches. Each of these serves `PORTS_PER_SW` external ports and has exactly one link to each of `NUM_MID` middle-stage switches. A connect request names an ingress switch and local port, and an egress switch and local port. The allocator looks up which middle-stage links the two named switches already use. It picks the lowest-numbered middle stage that is free on both sides, marks that link busy on both sides, and remembers the stage against the ingress port. It then answers with the chosen stage.

A release request names the same pair of ports. It frees the two links recorded for that circuit and reports the stage that was freed. When no stage is free on both sides, the request gets a blocked answer. A request that would break the one-circuit-per-port rule, or that names a port outside the switch, gets an error answer. Neither of these answers changes any state.

Requests use a valid/ready handshake. Every accepted request gets exactly one response, which appears as a single-cycle pulse on the clock after acceptance. The datapath crossbars and any rearrangement of circuits that already exist are outside this block.

Top module: `clos_path_alloc`

## Requirements
- R1: A connect request between free, in-range ports is answered, one clock after acceptance, with status GRANT (code 2'b00). The reported stage is the lowest-indexed middle stage whose link is unused both at the named ingress switch and at the named egress switch.
- R2: A granted stage is marked used at both switches before the next request is evaluated. A later connect involving either of those switches cannot receive that stage while the circuit exists.
- R3: If no middle stage is free on both sides, the response is BLOCKED (code 2'b01) with stage 0. No link or port state changes, so the same request stays blocked until a circuit is released.
- R4: A connect request whose ingress port or egress port already carries a circuit is answered with ERROR (code 2'b10) and changes no state.
- R5: A release request naming an ingress port and the egress port it is connected to is answered with FREED (code 2'b11) and the stage the circuit used. It frees that stage's link at both switches and frees both ports.
- R6: A release request naming a pair that is not connected to each other is answered with ERROR and changes no state.
- R7: A request naming a switch index at or above `NUM_SW`, or a local port at or above `PORTS_PER_SW`, is answered with ERROR and changes no state.
- R8: No ingress or egress switch ever has more than min(`NUM_MID`, `PORTS_PER_SW`) middle-stage links in use.
- R9: With `NUM_MID` >= 2*`PORTS_PER_SW`-1, no connect request between free, in-range ports is ever answered BLOCKED.
- R10: While reset is applied, `req_ready` and `rsp_valid` are low. `req_ready` rises within a few clocks of reset release.
- R11: `rsp_valid` is high for exactly one clock per accepted request and never without one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 1 | 0 = connect, 1 = release |
| req_in_sw | input | SW_W | Ingress switch index |
| req_in_port | input | LP_W | Local port on the ingress switch |
| req_out_sw | input | SW_W | Egress switch index |
| req_out_port | input | LP_W | Local port on the egress switch |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_status | output | 2 | 00 GRANT, 01 BLOCKED, 10 ERROR, 11 FREED |
| rsp_stage | output | STG_W | Granted or freed middle stage, else 0 |

## Verification
The bench builds two copies of the block. The first has 3 switches per side, 2 ports each and 3 middle stages. That is exactly 2m-1 stages, so a long run of random legal connects and releases can be checked against the claim that nothing ever blocks, with a directed case that reaches the worst-case union of two used stages and still gets the third. The second copy has 2 switches, 2 ports each and only 2 middle stages. In that copy a short sequence leaves ingress and egress using disjoint stages, so the blocked answer can be produced, repeated unchanged, and then cleared by a release.

// File: rtl/clos_pkg.sv
package clos_pkg;
  typedef enum logic [0:0] {
    OP_CONNECT = 1'b0,
    OP_RELEASE = 1'b1
  } clos_op_e;

  typedef enum logic [1:0] {
    ST_GRANT   = 2'b00,
    ST_BLOCKED = 2'b01,
    ST_ERROR   = 2'b10,
    ST_FREED   = 2'b11
  } clos_status_e;
endpackage

// File: rtl/clos_link_map.sv
// Per-switch middle-stage link usage: one NUM_MID-bit vector for each switch on one side.
module clos_link_map #(
  parameter int NUM_SW    = 3,
  parameter int NUM_MID   = 3,
  parameter int MAX_LINKS = 2,
  parameter int SW_W      = 2,
  parameter int STG_W     = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SW_W-1:0]    sel_sw,
  input  logic               set_en,
  input  logic               clr_en,
  input  logic [STG_W-1:0]   stg,
  output logic [NUM_MID-1:0] used_vec
);
  logic [NUM_MID-1:0] used_q [NUM_SW];
  logic [NUM_MID-1:0] used_d [NUM_SW];
  logic               upd_en;
  logic               sel_ok;

  assign sel_ok = (32'(sel_sw) < NUM_SW);
  assign upd_en = (set_en | clr_en) & sel_ok;

  always_comb begin
    used_vec = '0;
    if (sel_ok) used_vec = used_q[sel_sw];
  end

  always_comb begin
    for (int i = 0; i < NUM_SW; i++) used_d[i] = used_q[i];
    if (sel_ok && set_en) used_d[sel_sw][stg] = 1'b1;
    if (sel_ok && clr_en) used_d[sel_sw][stg] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SW; i++) used_q[i] <= '0;
    end else if (upd_en) begin
      for (int i = 0; i < NUM_SW; i++) used_q[i] <= used_d[i];
    end
  end

  AST_SET_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> (sel_ok && !used_q[sel_sw][stg])); // R2
  AST_CLEAR_ONLY_USED: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |-> (sel_ok && used_q[sel_sw][stg])); // R5
  AST_SET_CLR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_en && clr_en)); // R11

  generate
    for (genvar g = 0; g < NUM_SW; g++) begin : g_row
      AST_ROW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(used_q[g]) <= MAX_LINKS); // R8
    end
  endgenerate
endmodule

// File: rtl/clos_stage_pick.sv
// Candidate stages are those free on both sides; the lowest index wins.
module clos_stage_pick #(
  parameter int NUM_MID = 3,
  parameter int STG_W   = 2
) (
  input  logic [NUM_MID-1:0] used_a,
  input  logic [NUM_MID-1:0] used_b,
  output logic               found,
  output logic [STG_W-1:0]   stage
);
  logic [NUM_MID-1:0] cand;

  assign cand = ~(used_a | used_b);

  always_comb begin
    found = 1'b0;
    stage = '0;
    for (int i = NUM_MID - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        stage = STG_W'(i);
      end
    end
  end
endmodule

// File: rtl/clos_port_table.sv
// Circuit record per ingress port (busy, peer egress port, stage) and busy flag per egress port.
module clos_port_table #(
  parameter int NUM_PORTS = 6,
  parameter int PORT_W    = 3,
  parameter int STG_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] in_idx,
  input  logic [PORT_W-1:0] out_idx,
  input  logic              conn_en,
  input  logic              rel_en,
  input  logic [STG_W-1:0]  conn_stage,
  output logic              in_busy,
  output logic              out_busy,
  output logic [PORT_W-1:0] in_peer,
  output logic [STG_W-1:0]  in_stage
);
  logic              in_busy_q  [NUM_PORTS];
  logic              out_busy_q [NUM_PORTS];
  logic [PORT_W-1:0] peer_q     [NUM_PORTS];
  logic [STG_W-1:0]  stg_q      [NUM_PORTS];
  logic              in_ok, out_ok;
  logic              busy_in_d, busy_out_d;
  logic              wr_en;

  assign in_ok  = (32'(in_idx)  < NUM_PORTS);
  assign out_ok = (32'(out_idx) < NUM_PORTS);
  assign wr_en  = (conn_en | rel_en) & in_ok & out_ok;

  always_comb begin
    in_busy  = 1'b0;
    in_peer  = '0;
    in_stage = '0;
    out_busy = 1'b0;
    if (in_ok) begin
      in_busy  = in_busy_q[in_idx];
      in_peer  = peer_q[in_idx];
      in_stage = stg_q[in_idx];
    end
    if (out_ok) out_busy = out_busy_q[out_idx];
  end

  assign busy_in_d  = conn_en;
  assign busy_out_d = conn_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PORTS; i++) begin
        in_busy_q[i]  <= 1'b0;
        out_busy_q[i] <= 1'b0;
        peer_q[i]     <= '0;
        stg_q[i]      <= '0;
      end
    end else if (wr_en) begin
      in_busy_q[in_idx]   <= busy_in_d;
      out_busy_q[out_idx] <= busy_out_d;
      if (conn_en) begin
        peer_q[in_idx] <= out_idx;
        stg_q[in_idx]  <= conn_stage;
      end
    end
  end

  AST_CONNECT_PORTS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    conn_en |-> (in_ok && out_ok && !in_busy_q[in_idx] && !out_busy_q[out_idx])); // R4
  AST_RELEASE_HELD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    rel_en |-> (in_ok && out_ok && in_busy_q[in_idx] && peer_q[in_idx] == out_idx
                && out_busy_q[out_idx])); // R6
endmodule

// File: rtl/clos_path_alloc.sv
module clos_path_alloc
  import clos_pkg::*;
#(
  parameter int NUM_SW       = 3,
  parameter int PORTS_PER_SW = 2,
  parameter int NUM_MID      = 3,
  localparam int SW_W      = (NUM_SW > 1) ? $clog2(NUM_SW) : 1,
  localparam int LP_W      = (PORTS_PER_SW > 1) ? $clog2(PORTS_PER_SW) : 1,
  localparam int STG_W     = (NUM_MID > 1) ? $clog2(NUM_MID) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_op,
  input  logic [SW_W-1:0]  req_in_sw,
  input  logic [LP_W-1:0]  req_in_port,
  input  logic [SW_W-1:0]  req_out_sw,
  input  logic [LP_W-1:0]  req_out_port,
  output logic             rsp_valid,
  output logic [1:0]       rsp_status,
  output logic [STG_W-1:0] rsp_stage
);
  localparam int NUM_PORTS = NUM_SW * PORTS_PER_SW;
  localparam int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int MAX_LINKS = (NUM_MID < PORTS_PER_SW) ? NUM_MID : PORTS_PER_SW;

  // Reset synchronizer: asserts asynchronously, releases on the clock.
  logic rst_meta_q, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_ni     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_ni     <= rst_meta_q;
    end
  end

  logic ready_q;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) ready_q <= 1'b0;
    else         ready_q <= 1'b1;
  end
  assign req_ready = ready_q;

  logic               acc;
  logic               in_range, out_range;
  logic [PORT_W-1:0]  in_idx, out_idx;
  logic [NUM_MID-1:0] uil_vec, uol_vec;
  logic               cand_found;
  logic [STG_W-1:0]   cand_stage;
  logic               in_busy, out_busy;
  logic [PORT_W-1:0]  in_peer;
  logic [STG_W-1:0]   in_stage;
  logic               map_set, map_clr;
  logic [STG_W-1:0]   map_stg;
  logic               tbl_conn, tbl_rel;
  clos_status_e       status_d;
  logic [STG_W-1:0]   stage_d;
  clos_op_e           op;

  assign acc       = req_valid & ready_q;
  assign op        = clos_op_e'(req_op);
  assign in_range  = (32'(req_in_sw) < NUM_SW) && (32'(req_in_port) < PORTS_PER_SW);
  assign out_range = (32'(req_out_sw) < NUM_SW) && (32'(req_out_port) < PORTS_PER_SW);
  assign in_idx    = PORT_W'(32'(req_in_sw) * PORTS_PER_SW + 32'(req_in_port));
  assign out_idx   = PORT_W'(32'(req_out_sw) * PORTS_PER_SW + 32'(req_out_port));

  clos_link_map #(
    .NUM_SW(NUM_SW), .NUM_MID(NUM_MID), .MAX_LINKS(MAX_LINKS), .SW_W(SW_W), .STG_W(STG_W)
  ) u_ingress_map (
    .clk(clk), .rst_n(rst_ni), .sel_sw(req_in_sw), .set_en(map_set), .clr_en(map_clr),
    .stg(map_stg), .used_vec(uil_vec)
  );

  clos_link_map #(
    .NUM_SW(NUM_SW), .NUM_MID(NUM_MID), .MAX_LINKS(MAX_LINKS), .SW_W(SW_W), .STG_W(STG_W)
  ) u_egress_map (
    .clk(clk), .rst_n(rst_ni), .sel_sw(req_out_sw), .set_en(map_set), .clr_en(map_clr),
    .stg(map_stg), .used_vec(uol_vec)
  );

  clos_stage_pick #(.NUM_MID(NUM_MID), .STG_W(STG_W)) u_pick (
    .used_a(uil_vec), .used_b(uol_vec), .found(cand_found), .stage(cand_stage)
  );

  clos_port_table #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .STG_W(STG_W)) u_table (
    .clk(clk), .rst_n(rst_ni), .in_idx(in_idx), .out_idx(out_idx),
    .conn_en(tbl_conn), .rel_en(tbl_rel), .conn_stage(cand_stage),
    .in_busy(in_busy), .out_busy(out_busy), .in_peer(in_peer), .in_stage(in_stage)
  );

  // Decision for the request being accepted this cycle.
  always_comb begin
    status_d = ST_ERROR;
    stage_d  = '0;
    map_set  = 1'b0;
    map_clr  = 1'b0;
    map_stg  = cand_stage;
    tbl_conn = 1'b0;
    tbl_rel  = 1'b0;
    if (acc && in_range && out_range) begin
      if (op == OP_CONNECT) begin
        if (!in_busy && !out_busy) begin
          if (cand_found) begin
            status_d = ST_GRANT;
            stage_d  = cand_stage;
            map_set  = 1'b1;
            tbl_conn = 1'b1;
          end else begin
            status_d = ST_BLOCKED;
          end
        end
      end else begin
        if (in_busy && out_busy && in_peer == out_idx) begin
          status_d = ST_FREED;
          stage_d  = in_stage;
          map_stg  = in_stage;
          map_clr  = 1'b1;
          tbl_rel  = 1'b1;
        end
      end
    end
  end

  logic             rsp_valid_q;
  logic [1:0]       rsp_status_q;
  logic [STG_W-1:0] rsp_stage_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rsp_valid_q <= 1'b0;
    else         rsp_valid_q <= acc;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_status_q <= '0;
      rsp_stage_q  <= '0;
    end else if (acc) begin
      rsp_status_q <= status_d;
      rsp_stage_q  <= stage_d;
    end
  end

  assign rsp_valid  = rsp_valid_q;
  assign rsp_status = rsp_status_q;
  assign rsp_stage  = rsp_stage_q;

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_ni)
    rsp_valid |-> $past(req_valid && req_ready)); // R11
  AST_GRANT_STAGE_RANGE: assert property (@(posedge clk) disable iff (!rst_ni)
    (rsp_valid && rsp_status == ST_GRANT) |-> (32'(rsp_stage) < NUM_MID)); // R1
  AST_BLOCKED_STAGE_ZERO: assert property (@(posedge clk) disable iff (!rst_ni)
    (rsp_valid && rsp_status == ST_BLOCKED) |-> (rsp_stage == '0)); // R3
  AST_RANGE_ERROR: assert property (@(posedge clk) disable iff (!rst_ni)
    (acc && !(in_range && out_range)) |=> (rsp_status == ST_ERROR)); // R7

  generate
    if (NUM_MID >= 2 * PORTS_PER_SW - 1) begin : g_nonblocking
      AST_NEVER_BLOCKED: assert property (@(posedge clk) disable iff (!rst_ni)
        rsp_valid |-> (rsp_status != ST_BLOCKED)); // R9
    end
  endgenerate
endmodule

// File: tb/clos_path_alloc_test.sv
module clos_path_alloc_test;
  localparam int ST_GRANT = 0, ST_BLOCKED = 1, ST_ERROR = 2, ST_FREED = 3;
  localparam int A_SW = 3, A_M = 2, A_R = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Configuration A: 3 switches, 2 ports, 3 middle stages (R = 2m-1)
  logic a_valid = 1'b0, a_op = 1'b0;
  logic [1:0] a_isw = '0, a_osw = '0;
  logic a_ip = 1'b0, a_opt = 1'b0;
  logic a_ready, a_rsp_valid;
  logic [1:0] a_status, a_stage;

  // Configuration B: 2 switches, 2 ports, 2 middle stages (R < 2m-1)
  logic b_valid = 1'b0, b_op = 1'b0;
  logic b_isw = 1'b0, b_osw = 1'b0;
  logic b_ip = 1'b0, b_opt = 1'b0;
  logic b_ready, b_rsp_valid;
  logic [1:0] b_status;
  logic b_stage;

  clos_path_alloc #(.NUM_SW(A_SW), .PORTS_PER_SW(A_M), .NUM_MID(A_R)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(a_valid), .req_ready(a_ready), .req_op(a_op),
    .req_in_sw(a_isw), .req_in_port(a_ip), .req_out_sw(a_osw), .req_out_port(a_opt),
    .rsp_valid(a_rsp_valid), .rsp_status(a_status), .rsp_stage(a_stage)
  );

  clos_path_alloc #(.NUM_SW(2), .PORTS_PER_SW(2), .NUM_MID(2)) uut_blk (
    .clk(clk), .rst_n(rst_n), .req_valid(b_valid), .req_ready(b_ready), .req_op(b_op),
    .req_in_sw(b_isw), .req_in_port(b_ip), .req_out_sw(b_osw), .req_out_port(b_opt),
    .rsp_valid(b_rsp_valid), .rsp_status(b_status), .rsp_stage(b_stage)
  );

  task automatic check(string tag, int act_st, int act_stg, int exp_st, int exp_stg);
    checks++;
    if (act_st != exp_st || act_stg != exp_stg) begin
      errors++;
      $display("FAIL %s: status=%0d stage=%0d expected status=%0d stage=%0d",
               tag, act_st, act_stg, exp_st, exp_stg);
    end
  endtask

  // Issue one request to config sel (0 = A, 1 = B) and compare the response.
  task automatic issue(string tag, int sel, int op, int isw, int ip, int osw, int opt,
                       int exp_st, int exp_stg);
    int st, stg;
    @(negedge clk);
    if (sel == 0) begin
      a_valid = 1'b1; a_op = op[0]; a_isw = 2'(isw); a_ip = ip[0];
      a_osw = 2'(osw); a_opt = opt[0];
    end else begin
      b_valid = 1'b1; b_op = op[0]; b_isw = isw[0]; b_ip = ip[0];
      b_osw = osw[0]; b_opt = opt[0];
    end
    @(negedge clk);
    a_valid = 1'b0;
    b_valid = 1'b0;
    if (sel == 0) begin
      st  = a_rsp_valid ? int'(a_status) : -1;
      stg = int'(a_stage);
    end else begin
      st  = b_rsp_valid ? int'(b_status) : -1;
      stg = int'(b_stage);
    end
    check(tag, st, stg, exp_st, exp_stg);
    @(negedge clk);
    check("R11 single response pulse", int'(a_rsp_valid), int'(b_rsp_valid), 0, 0);
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 ready low in reset", int'(a_ready), int'(b_ready), 0, 0);
    check("R10 rsp_valid low in reset", int'(a_rsp_valid), int'(b_rsp_valid), 0, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 ready after release", int'(a_ready), int'(b_ready), 1, 1);
    check("R11 no response without request", int'(a_rsp_valid), int'(b_rsp_valid), 0, 0);
  endtask

  // Random legal traffic on config A against a model of the link sets.
  task automatic test_random_nonblocking();
    int in_busy[A_SW*A_M], in_peer[A_SW*A_M], in_stg[A_SW*A_M], out_busy[A_SW*A_M];
    int uil[A_SW][A_R], uol[A_SW][A_R];
    foreach (in_busy[i]) begin in_busy[i] = 0; out_busy[i] = 0; in_peer[i] = 0; in_stg[i] = 0; end
    foreach (uil[i, j]) begin uil[i][j] = 0; uol[i][j] = 0; end
    for (int n = 0; n < 500; n++) begin
      int p = $urandom_range(0, A_SW*A_M-1);
      if (in_busy[p] != 0) begin
        int q = in_peer[p];
        int s = in_stg[p];
        issue("R5 random release", 0, 1, p / A_M, p % A_M, q / A_M, q % A_M, ST_FREED, s);
        uil[p / A_M][s] = 0; uol[q / A_M][s] = 0;
        in_busy[p] = 0; out_busy[q] = 0;
      end else begin
        int q = $urandom_range(0, A_SW*A_M-1);
        int s = -1;
        while (out_busy[q] != 0) q = (q + 1) % (A_SW*A_M);
        for (int k = A_R - 1; k >= 0; k--)
          if (uil[p / A_M][k] == 0 && uol[q / A_M][k] == 0) s = k;
        if (s < 0) begin
          check("R9 model found no stage", s, 0, 0, 0);
        end else begin
          issue("R9 random connect never blocked", 0, 0, p / A_M, p % A_M, q / A_M, q % A_M,
                ST_GRANT, s);
          uil[p / A_M][s] = 1; uol[q / A_M][s] = 1;
          in_busy[p] = 1; out_busy[q] = 1; in_peer[p] = q; in_stg[p] = s;
        end
      end
    end
    for (int p = 0; p < A_SW*A_M; p++) begin
      if (in_busy[p] != 0) begin
        int q = in_peer[p];
        issue("R5 drain release", 0, 1, p / A_M, p % A_M, q / A_M, q % A_M, ST_FREED, in_stg[p]);
        in_busy[p] = 0;
      end
    end
  endtask

  task automatic test_directed_a();
    issue("R1 first grant lowest stage", 0, 0, 0, 0, 0, 0, ST_GRANT, 0);
    issue("R1 other switches stage 0", 0, 0, 1, 0, 1, 0, ST_GRANT, 0);
    issue("R2 stage 0 taken at I1", 0, 0, 1, 1, 1, 1, ST_GRANT, 1);
    issue("R5 release reports stage", 0, 1, 1, 0, 1, 0, ST_FREED, 0);
    issue("R9 worst-case union still grants", 0, 0, 0, 1, 1, 0, ST_GRANT, 2);
    issue("R4 ingress port busy", 0, 0, 0, 0, 2, 0, ST_ERROR, 0);
    issue("R4 egress port busy", 0, 0, 2, 0, 0, 0, ST_ERROR, 0);
    issue("R4 no state change after error", 0, 0, 2, 0, 2, 0, ST_GRANT, 0);
    issue("R6 release of idle pair", 0, 1, 2, 1, 2, 1, ST_ERROR, 0);
    issue("R6 release with wrong peer", 0, 1, 0, 0, 1, 0, ST_ERROR, 0);
    issue("R6 circuit intact after error", 0, 1, 0, 0, 0, 0, ST_FREED, 0);
    issue("R7 connect to switch 3", 0, 0, 3, 0, 0, 1, ST_ERROR, 0);
    issue("R7 release from switch 3", 0, 1, 0, 1, 3, 0, ST_ERROR, 0);
    issue("R5 freed stage reused", 0, 0, 1, 0, 0, 0, ST_GRANT, 0);
  endtask

  task automatic test_directed_b();
    issue("R1 config B first grant", 1, 0, 0, 0, 0, 0, ST_GRANT, 0);
    issue("R1 config B second grant", 1, 0, 1, 0, 1, 0, ST_GRANT, 0);
    issue("R2 config B next stage", 1, 0, 1, 1, 1, 1, ST_GRANT, 1);
    issue("R5 config B release", 1, 1, 1, 0, 1, 0, ST_FREED, 0);
    issue("R3 disjoint sets block", 1, 0, 0, 1, 1, 0, ST_BLOCKED, 0);
    issue("R3 still blocked on retry", 1, 0, 0, 1, 1, 0, ST_BLOCKED, 0);
    issue("R3 blocked port left free", 1, 0, 0, 1, 0, 1, ST_GRANT, 1);
    issue("R5 config B release stage 1", 1, 1, 0, 1, 0, 1, ST_FREED, 1);
    issue("R5 config B release stage 0", 1, 1, 0, 0, 0, 0, ST_FREED, 0);
    issue("R3 grant after release clears block", 1, 0, 0, 1, 1, 0, ST_GRANT, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: status=%0d stage=%0d expected status=%0d stage=%0d", 0, 0, 1, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_random_nonblocking();
    test_directed_a();
    test_directed_b();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule